// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block lets a host read and write the 16-bit management registers of external Ethernet PHYs over the two-wire MDIO bus. The host uses a small set of 32-bit registers. It programs a target PHY address and register number, then either writes a data word, which starts a write frame, or raises a read request bit, which starts a read frame. The block generates MDC from the system clock with a programmable divisor. It serializes Clause 22 frames on MDIO and, for reads, releases the line and shifts the PHY's answer into a read-data register.

Two flags show progress. A busy flag covers the whole frame. A not-valid flag covers a read from its start until its data has been captured. Software polls both flags. Setting the top bit of the configuration register aborts any frame at once and puts the bus back to idle.

Top module: `mdio_host_ctrl`

## Requirements
- R1: After reset, the indication register (select 5) reads 0 and the configuration register (select 0) reads the divisor 7 in bits 2:0. MDC is high and MDIO is released (mdio_oe low).
- R2: The address register (select 2) keeps the PHY address in bits 12:8 and the register number in bits 4:0. All its other bits read 0.
- R3: Writing the write-data register (select 3) while idle starts a write frame, sent MSB first with one bit per MDC period, each bit changing as MDC falls. The frame is 32 ones, then 01, then opcode 01, the PHY address, the register number, the turnaround 10, and the 16 data bits.
- R4: Writing 1 to bit 0 of the command register (select 1) starts a read frame only if the stored bit was 0. Writing 1 over a stored 1 starts nothing.
- R5: A read frame carries opcode 10 and releases MDIO from the turnaround to the last data bit. It samples mdio_i in the system cycle before each MDC rise of the 16 data bits. At frame end, it places the word MSB first in bits 15:0 of the read-data register (select 4).
- R6: Indication bit 0 (busy) is set at the clock edge that accepts the starting write. It stays set for exactly 128 MDC half-periods.
- R7: Indication bit 2 (not-valid) is set at the edge that starts a read and clears at the edge that loads the read data. It is never set while the block is idle.
- R8: A configuration write with bit 31 set aborts at that edge:
  - busy and not-valid clear;
  - MDC returns high and MDIO is released;
  - the read-data register keeps its value;
  - the divisor in the same write takes effect.
- R9: The MDC half-period is 2^(d+1) system clocks, where d is configuration bits 2:0. The first low half begins at the start edge, and MDC is held high while idle.
- R10: While busy, writes to the address, write-data and command registers are ignored. Their stored values do not change and no frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register select for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven when mdio_oe is high |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
- **Start timing:** a write accepted at edge N shows up after that same edge: busy reads 1 and MDC is low.
- **End timing:** busy clears and the read data appears exactly at edge N+128H, where H is the half-period in clocks.
- **Per-cycle model:** the bench model counts clocks from the start edge, so bit index and MDC phase follow from division alone. MDC, the output enable and each driven bit are compared on every falling clock edge.
- **Frame-end checks:** the explicit checks read the indication register one cycle before and one cycle after edge N+128H, using a free-running edge counter. This pins the frame length to a single clock.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int REG_W     = 32;
    localparam int SEL_W     = 3;
    localparam int DIV_W     = 3;
    localparam int DATA_W    = 16;
    localparam int PHY_W     = 5;
    localparam int PRE_W     = 32;
    localparam int FRAME_W   = PRE_W + 2 + 2 + 2 * PHY_W + 2 + DATA_W;
    localparam int BIT_W     = $clog2(FRAME_W);
    localparam int CNT_W     = 1 << DIV_W;
    localparam int TA_BIT    = PRE_W + 4 + 2 * PHY_W;
    localparam int DATA_BIT  = TA_BIT + 2;
    localparam int DIV_RESET = 7;
    localparam int ABORT_BIT = 31;
    localparam int PHY_LSB   = 8;

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG  = 3'd0,
        SEL_CMD  = 3'd1,
        SEL_TGT  = 3'd2,
        SEL_WDAT = 3'd3,
        SEL_RDAT = 3'd4,
        SEL_IND  = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_WR = 2'b01,
        OP_RD = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic [PHY_W-1:0] phy;
        logic [PHY_W-1:0] regn;
    } mdio_tgt_t;

    function automatic logic [FRAME_W-1:0] build_frame(
        input mdio_op_e op, input mdio_tgt_t t, input logic [DATA_W-1:0] d);
        logic [1:0] ta;
        ta = (op == OP_RD) ? 2'b11 : 2'b10;
        return {{PRE_W{1'b1}}, 2'b01, op, t.phy, t.regn, ta, d};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick_rise,
    output logic             tick_end,
    output logic             mdc
);
    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic [CNT_W-1:0] lim;
    logic             wrap;

    // half period minus one: 2^(div+1) - 1
    assign lim  = CNT_W'((32'd1 << (int'(div) + 1)) - 32'd1);
    assign wrap = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (run) begin
            if (cnt_q == lim) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick_rise = wrap && !phase_q;
    assign tick_end  = wrap && phase_q;
    assign mdc       = !run || phase_q;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               abort,
    input  logic               start,
    input  logic               start_rd,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               tick_rise,
    input  logic               tick_end,
    input  logic               mdio_i,
    output logic               busy,
    output logic               is_rd,
    output logic               done,
    output logic [DATA_W-1:0]  rx_data,
    output logic               mdio_o,
    output logic               mdio_oe
);
    logic               busy_q;
    logic               rd_q;
    logic [BIT_W-1:0]   bit_q;
    logic [FRAME_W-1:0] sh_q;
    logic [DATA_W-1:0]  rx_q;
    logic               last;

    assign last = (bit_q == BIT_W'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            bit_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            rd_q   <= start_rd;
            bit_q  <= '0;
            sh_q   <= frame_in;
        end else if (busy_q) begin
            if (tick_rise && rd_q && (bit_q >= BIT_W'(DATA_BIT)))
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            if (tick_end) begin
                sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
                if (last)
                    busy_q <= 1'b0;
            end
        end
    end

    assign busy    = busy_q;
    assign is_rd   = rd_q;
    assign done    = busy_q && tick_end && last;
    assign rx_data = rx_q;
    assign mdio_oe = busy_q && !(rd_q && (bit_q >= BIT_W'(TA_BIT)));
    assign mdio_o  = mdio_oe & sh_q[FRAME_W-1];

endmodule

// File: rtl/mdio_host_ctrl.sv
module mdio_host_ctrl
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    reg_sel_e           sel;
    logic [DIV_W-1:0]   div_q;
    logic               cmd_q;
    mdio_tgt_t          tgt_q;
    logic [DATA_W-1:0]  wdat_q;
    logic [DATA_W-1:0]  rdat_q;
    logic               nv_q;

    logic               busy, is_rd, done;
    logic               tick_rise, tick_end;
    logic [DATA_W-1:0]  rx_data;
    logic               cfg_wr, abort, open, start_wr, start_rd, start;
    logic [FRAME_W-1:0] frame;
    logic               unused_wdata;

    assign sel          = reg_sel_e'(reg_addr);
    assign cfg_wr       = reg_wr && (sel == SEL_CFG);
    assign abort        = cfg_wr && reg_wdata[ABORT_BIT];
    assign open         = reg_wr && !busy;
    assign start_wr     = open && (sel == SEL_WDAT);
    assign start_rd     = open && (sel == SEL_CMD) && reg_wdata[0] && !cmd_q;
    assign start        = start_wr || start_rd;
    assign frame        = build_frame(start_rd ? OP_RD : OP_WR, tgt_q, reg_wdata[DATA_W-1:0]);
    assign unused_wdata = ^reg_wdata[ABORT_BIT-1:DATA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= DIV_W'(DIV_RESET);
            cmd_q  <= 1'b0;
            tgt_q  <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            nv_q   <= 1'b0;
        end else begin
            if (cfg_wr)
                div_q <= reg_wdata[DIV_W-1:0];
            if (open && (sel == SEL_CMD))
                cmd_q <= reg_wdata[0];
            if (open && (sel == SEL_TGT)) begin
                tgt_q.phy  <= reg_wdata[PHY_LSB +: PHY_W];
                tgt_q.regn <= reg_wdata[PHY_W-1:0];
            end
            if (start_wr)
                wdat_q <= reg_wdata[DATA_W-1:0];
            if (done && is_rd)
                rdat_q <= rx_data;
            if (abort)
                nv_q <= 1'b0;
            else if (start_rd)
                nv_q <= 1'b1;
            else if (done && is_rd)
                nv_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CFG:  reg_rdata[DIV_W-1:0] = div_q;
            SEL_CMD:  reg_rdata[0] = cmd_q;
            SEL_TGT: begin
                reg_rdata[PHY_LSB +: PHY_W] = tgt_q.phy;
                reg_rdata[PHY_W-1:0]        = tgt_q.regn;
            end
            SEL_WDAT: reg_rdata[DATA_W-1:0] = wdat_q;
            SEL_RDAT: reg_rdata[DATA_W-1:0] = rdat_q;
            SEL_IND: begin
                reg_rdata[0] = busy;
                reg_rdata[2] = nv_q;
            end
            default:  reg_rdata = '0;
        endcase
    end

    mdio_mdc_gen u_mdc (
        .clk       (clk),
        .rst       (rst),
        .clear     (start || abort),
        .run       (busy),
        .div       (div_q),
        .tick_rise (tick_rise),
        .tick_end  (tick_end),
        .mdc       (mdc)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .abort     (abort),
        .start     (start),
        .start_rd  (start_rd),
        .frame_in  (frame),
        .tick_rise (tick_rise),
        .tick_end  (tick_end),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .is_rd     (is_rd),
        .done      (done),
        .rx_data   (rx_data),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

endmodule

// File: rtl/mdio_host_ctrl_chk.sv
module mdio_host_ctrl_chk
    import mdio_mgmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [SEL_W-1:0] reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic             mdc,
    input logic             mdio_oe,
    input logic             busy,
    input logic             nv,
    input logic [DIV_W-1:0] div,
    input mdio_tgt_t        tgt
);
    logic       abort_w;
    logic       mdc_d;
    logic [9:0] run_q;
    logic [9:0] half;

    assign abort_w = reg_wr && (reg_addr == SEL_CFG) && reg_wdata[ABORT_BIT];
    assign half    = 10'd1 << (4'(div) + 4'd1);

    // length of the current MDC level, in clocks
    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_d <= 1'b1;
            run_q <= '0;
        end else begin
            mdc_d <= mdc;
            if (mdc != mdc_d)
                run_q <= 10'd1;
            else if (run_q != 10'h3FF)
                run_q <= run_q + 10'd1;
        end
    end

    AST_NV_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        nv |-> busy); // R7

    AST_READ_NEEDS_CMD_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(nv) |-> ($past(reg_wr) && ($past(reg_addr) == SEL_CMD) && $past(reg_wdata[0]))); // R4

    AST_TARGET_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(tgt)); // R10

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(abort_w) |-> (!busy && !nv && mdc && !mdio_oe)); // R8

    AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (mdc != mdc_d)) |-> (run_q == half)); // R9

endmodule

bind mdio_host_ctrl mdio_host_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .nv        (nv_q),
    .div       (div_q),
    .tgt       (tgt_q)
);

// File: tb/mdio_host_ctrl_test.sv
`timescale 1ns/1ps
module mdio_host_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    mdio_host_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cyc = 0;

    // behavioural reference state
    bit          m_busy, m_rd, m_nv, m_cmd;
    int          m_cyc, m_h;
    logic [63:0] m_frame;
    logic [2:0]  m_div;
    logic [4:0]  m_phy, m_reg;
    logic [15:0] m_wd, m_rdat;
    bit          rxq[$];
    logic [15:0] phy_resp = 16'h0000;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    always @(posedge clk) begin : model
        bit pb;
        int pos, bitn;
        if (rst) begin
            m_busy = 0; m_rd = 0; m_nv = 0; m_cmd = 0; m_cyc = 0; m_h = 2;
            m_frame = '0; m_div = 3'd7; m_phy = '0; m_reg = '0; m_wd = '0; m_rdat = '0;
            rxq.delete();
        end else begin
            pb = m_busy;
            if (m_busy) begin
                pos  = m_cyc % (2 * m_h);
                bitn = m_cyc / (2 * m_h);
                if (m_rd && bitn >= 48 && pos == m_h - 1) rxq.push_back(mdio_i);
                m_cyc++;
                if (m_cyc == 128 * m_h) begin
                    m_busy = 0;
                    if (m_rd) begin
                        m_rdat = '0;
                        foreach (rxq[k]) m_rdat = {m_rdat[14:0], rxq[k]};
                        rxq.delete();
                        m_nv = 0;
                    end
                end
            end
            if (reg_wr) begin
                if (reg_addr == 3'd0) begin
                    m_div = reg_wdata[2:0];
                    if (reg_wdata[31]) begin m_busy = 0; m_nv = 0; rxq.delete(); end
                end else if (!pb) begin
                    case (reg_addr)
                        3'd1: begin
                            if (reg_wdata[0] && !m_cmd) begin
                                m_busy = 1; m_rd = 1; m_nv = 1; m_cyc = 0;
                                m_h = 1 << (int'(m_div) + 1);
                                m_frame = {32'hFFFF_FFFF, 2'b01, 2'b10, m_phy, m_reg, 18'h3FFFF};
                                rxq.delete();
                            end
                            m_cmd = reg_wdata[0];
                        end
                        3'd2: begin m_phy = reg_wdata[12:8]; m_reg = reg_wdata[4:0]; end
                        3'd3: begin
                            m_wd = reg_wdata[15:0];
                            m_busy = 1; m_rd = 0; m_cyc = 0;
                            m_h = 1 << (int'(m_div) + 1);
                            m_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, m_phy, m_reg, 2'b10, m_wd};
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // per-cycle comparison and PHY response
    always @(negedge clk) begin : compare
        int pos, bitn;
        bit emdc, eoe;
        if (!rst && !finished) begin
            bitn = 0;
            if (m_busy) begin
                pos  = m_cyc % (2 * m_h);
                bitn = m_cyc / (2 * m_h);
                emdc = (pos >= m_h);
                eoe  = !(m_rd && bitn >= 46);
                mdio_i = (m_rd && bitn >= 48) ? phy_resp[63 - bitn] : 1'b1;
            end else begin
                emdc = 1'b1;
                eoe  = 1'b0;
                mdio_i = 1'b1;
            end
            check(mdc === emdc, "R9 mdc level", {31'd0, mdc}, {31'd0, emdc});
            check(mdio_oe === eoe, "R5 mdio_oe", {31'd0, mdio_oe}, {31'd0, eoe});
            if (eoe)
                check(mdio_o === m_frame[63 - bitn], "R3 frame bit", {31'd0, mdio_o}, {31'd0, m_frame[63 - bitn]});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // samples one cycle before and one cycle after edge st + 128*h
    task automatic wait_done(input int st, input int h, input logic [31:0] pre, input string tag);
        logic [31:0] v;
        while (cyc < st + 128 * h - 1) @(negedge clk);
        rd(3'd5, v);
        check(v == pre, {tag, " busy until last edge"}, v, pre);
        @(negedge clk);
        rd(3'd5, v);
        check(v == 32'd0, {tag, " idle after frame"}, v, 32'd0);
    endtask

    initial begin : main
        logic [31:0] v;
        int st;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd5, v); check(v == 32'd0, "R1 indication", v, 32'd0);
        rd(3'd0, v); check(v == 32'd7, "R1 divisor", v, 32'd7);
        check(mdc === 1'b1 && mdio_oe === 1'b0, "R1 idle pins", {30'd0, mdc, mdio_oe}, 32'd2);

        // R9 divisor readback
        wr(3'd0, 32'd0);
        rd(3'd0, v); check(v == 32'd0, "R9 divisor write", v, 32'd0);

        // R2 address fields
        wr(3'd2, 32'hFFFF_F3F7);
        rd(3'd2, v); check(v == 32'h0000_1317, "R2 address fields", v, 32'h0000_1317);
        wr(3'd2, 32'h0000_110A);

        // R3 write frame, R6 length, R10 ignored writes
        wr(3'd3, 32'h0000_BEEF);
        st = cyc;
        rd(3'd5, v); check(v == 32'd1, "R6 busy after start", v, 32'd1);
        wr(3'd2, 32'h0000_0505);
        wr(3'd3, 32'h0000_1111);
        wr(3'd1, 32'd1);
        wait_done(st, 2, 32'd1, "R6");
        rd(3'd2, v); check(v == 32'h0000_110A, "R10 address kept", v, 32'h0000_110A);
        rd(3'd1, v); check(v == 32'd0, "R10 command kept", v, 32'd0);
        rd(3'd3, v); check(v == 32'h0000_BEEF, "R10 write data kept", v, 32'h0000_BEEF);

        // R4 R5 R7 read frame
        wr(3'd0, 32'd1);
        phy_resp = 16'hA5C3;
        wr(3'd1, 32'd1);
        st = cyc;
        rd(3'd5, v); check(v == 32'd5, "R7 not-valid at read start", v, 32'd5);
        wait_done(st, 4, 32'd5, "R7");
        rd(3'd4, v); check(v == 32'h0000_A5C3, "R5 read data", v, 32'h0000_A5C3);

        // R4 no restart over a stored 1
        wr(3'd1, 32'd1);
        @(negedge clk);
        rd(3'd5, v); check(v == 32'd0, "R4 no read without 0-to-1", v, 32'd0);
        phy_resp = 16'h1234;
        wr(3'd1, 32'd0);
        rd(3'd5, v); check(v == 32'd0, "R4 writing 0 starts nothing", v, 32'd0);
        wr(3'd1, 32'd1);
        st = cyc;
        rd(3'd5, v); check(v == 32'd5, "R4 read on rising bit", v, 32'd5);
        wait_done(st, 4, 32'd5, "R5");
        rd(3'd4, v); check(v == 32'h0000_1234, "R5 second read data", v, 32'h0000_1234);

        // R8 abort mid-read
        wr(3'd1, 32'd0);
        phy_resp = 16'hFFFF;
        wr(3'd1, 32'd1);
        repeat (40) @(negedge clk);
        rd(3'd5, v); check(v == 32'd5, "R8 busy before abort", v, 32'd5);
        wr(3'd0, 32'h8000_0002);
        rd(3'd5, v); check(v == 32'd0, "R8 flags cleared", v, 32'd0);
        check(mdc === 1'b1 && mdio_oe === 1'b0, "R8 pins idle", {30'd0, mdc, mdio_oe}, 32'd2);
        rd(3'd4, v); check(v == 32'h0000_1234, "R8 read data kept", v, 32'h0000_1234);
        rd(3'd0, v); check(v == 32'd2, "R8 divisor taken", v, 32'd2);

        // R9 slower rate write frame
        wr(3'd3, 32'h0000_0F0F);
        st = cyc;
        wait_done(st, 8, 32'd1, "R9");
        rd(3'd5, v); check(v == 32'd0, "R7 idle no not-valid", v, 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R6 watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule